// File: doc/BRIEF.md
# Abstract Register-Access Command Generator

This block sits inside a debug controller and turns an abstract command word into the two instruction words that a halted hart fetches from the debug program area. A start strobe asks for the command to be carried out. The block checks the controller's current busy flag, its error field and the halted state of the selected hart. It then does one of three things: it accepts the command, it records one error code, or it does nothing.

On acceptance the block writes both instruction words. When the command moves a register, word 0 is a load or a store between a general-purpose register and the shared data area, addressed by a 12-bit offset from x0. Otherwise word 0 is a no-op. Word 1 is either a no-op, so that the hart runs on into the program buffer, or a breakpoint that returns it to the debug loop. At the same time the block pulses a busy-set strobe and a go strobe for the selected hart. The surrounding controller owns the busy flag, the error field and the per-hart go flags, and uses these strobes to update them.

Command fields are: command type in bits 31:24, access size in bits 22:20, postexec in bit 18, transfer in bit 17, write in bit 16, and register number in bits 15:0. Bits 23 and 19 are ignored. All results are registered, so they appear in the cycle after the start strobe.

Top module: `abs_cmd_gen`

## Requirements
- R1: While reset is held low at a clock edge, and in the first cycle after it, busy_set, go_set and err_we are 0, err_code is 0, word0 is 0x00000013 and word1 is 0x00100073.
- R2: A start while err_in is nonzero has no effect: no strobe is raised and both words keep their values.
- R3: A start with err_in zero and busy_in set raises err_we with err_code 1 (busy) and raises neither busy_set nor go_set.
- R4: With err_in zero and busy_in clear, a command whose bits 31:24 are not zero records err_code 2 (not supported).
- R5: A command of type zero while hart_halted is low records err_code 4 (halt/resume). This is checked after R4 and before any field check.
- R6: With transfer set, a register number outside 0x1000 to 0x101F records err_code 2.
- R7: With transfer set and a valid register number, a size other than 2 (32-bit) or 3 (64-bit) records err_code 2.
- R8: An accepted transfer with write set makes word0 a load into GPR (regno-0x1000) from the data offset with base x0: imm[11:0] in bits 31:20, funct3 010 for size 2 or 011 for size 3 in bits 14:12, rd in bits 11:7, opcode 0000011.
- R9: An accepted transfer with write clear makes word0 a store of that GPR to the data offset with base x0: imm[11:5] in bits 31:25, rs2 in bits 24:20, funct3 as in R8, imm[4:0] in bits 11:7, opcode 0100011.
- R10: An accepted command with transfer clear makes word0 0x00000013, whatever its size and register number.
- R11: On acceptance, word1 is 0x00000013 when postexec is set and 0x00100073 otherwise.
- R12: On acceptance, busy_set and go_set pulse together while err_we stays 0. A rejected or ignored command leaves both words unchanged.
- R13: Every strobe appears exactly one cycle after the start and lasts a single cycle. err_code is 0 whenever err_we is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to carry out the command on this cycle |
| command | input | 32 | Abstract command word |
| hart_halted | input | 1 | Selected hart is halted |
| busy_in | input | 1 | Controller's current busy flag |
| err_in | input | 3 | Controller's current error field |
| word0 | output | 32 | First instruction word for the hart |
| word1 | output | 32 | Second instruction word for the hart |
| busy_set | output | 1 | One-cycle pulse: set the busy flag |
| go_set | output | 1 | One-cycle pulse: set the go flag of the selected hart |
| err_we | output | 1 | One-cycle pulse: write err_code into the error field |
| err_code | output | 3 | Error code to record |

## Verification
The main sweep crosses all eight sizes, all eight combinations of postexec, transfer and write, register numbers on both sides of each edge of the GPR window (0x0FFF, 0x1000, 0x101F, 0x1020 and values far outside it), and both halted states. This separates a valid transfer from the range and size rejections, and shows that transfer-clear commands ignore size and register number. Further runs set the command type to nonzero values, hold busy_in, or give every nonzero err_in value. These cases check the order of the precondition checks and that the words are left alone after a rejection. After every start the next idle cycle is also checked, so that a strobe lasting more than one cycle is caught.

// File: rtl/abs_cmd_pkg.sv
// Package: shared codes, instruction constants and encoders for the
// abstract command generator. Assumes RV32/RV64 base integer encodings.
package abs_cmd_pkg;

    // Error codes written into the controller's error field
    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_BUSY    = 3'd1,
        ERR_NOTSUP  = 3'd2,
        ERR_EXCEPT  = 3'd3,
        ERR_HALTRES = 3'd4
    } cmd_err_e;

    localparam int REG_IDX_W = 5;   // width of a GPR field in an instruction

    localparam logic [31:0] INSN_NOP    = 32'h0000_0013;
    localparam logic [31:0] INSN_EBREAK = 32'h0010_0073;

    localparam logic [6:0] OPC_LOAD  = 7'b000_0011;
    localparam logic [6:0] OPC_STORE = 7'b010_0011;
    localparam logic [2:0] F3_WORD   = 3'b010;
    localparam logic [2:0] F3_DBL    = 3'b011;

    // Load: rd <- mem[x0 + imm]
    function automatic logic [31:0] mk_load(input logic [2:0] f3,
                                            input logic [REG_IDX_W-1:0] rd,
                                            input logic [11:0] imm);
        return {imm, 5'd0, f3, rd, OPC_LOAD};
    endfunction

    // Store: mem[x0 + imm] <- rs2
    function automatic logic [31:0] mk_store(input logic [2:0] f3,
                                             input logic [REG_IDX_W-1:0] rs2,
                                             input logic [11:0] imm);
        return {imm[11:5], rs2, 5'd0, f3, imm[4:0], OPC_STORE};
    endfunction

endpackage

// File: rtl/abs_cmd_check.sv
// Module: precondition and field checker. Purely combinational; decides
// whether a command would be accepted, rejected with a code, or ignored.
// Assumes the caller gates every result with the start strobe.
module abs_cmd_check
    import abs_cmd_pkg::*;
#(
    parameter logic [15:0] GPR_BASE   = 16'h1000,
    parameter int          GPR_COUNT  = 32,
    parameter bit          ALLOW_DBL  = 1'b1
) (
    input  logic [7:0]            kind,
    input  logic [2:0]            size,
    input  logic                  transfer,
    input  logic [15:0]           regno,
    input  logic                  halted,
    input  logic                  busy,
    input  logic [2:0]            err,
    output logic                  accept,
    output logic                  reject,
    output cmd_err_e              code,
    output logic                  dbl,
    output logic [REG_IDX_W-1:0]  gpr_idx
);

    localparam logic [16:0] GPR_END = {1'b0, GPR_BASE} + 17'(GPR_COUNT);

    logic        range_ok;
    logic        size_ok;
    logic [15:0] offset;

    // Register number window and GPR index
    always_comb begin
        offset   = regno - GPR_BASE;
        range_ok = (regno >= GPR_BASE) && ({1'b0, regno} < GPR_END);
        gpr_idx  = offset[REG_IDX_W-1:0];
        dbl      = (size == 3'd3);
    end

    // Size legality depends on whether 64-bit transfers are built in
    generate
        if (ALLOW_DBL) begin : g_dbl
            assign size_ok = (size == 3'd2) || (size == 3'd3);
        end else begin : g_word
            assign size_ok = (size == 3'd2);
        end
    endgenerate

    // Ordered precondition checks
    always_comb begin
        accept = 1'b0;
        reject = 1'b0;
        code   = ERR_NONE;
        if (err != 3'd0) begin
            // pending error: ignore the request
        end else if (busy) begin
            reject = 1'b1;
            code   = ERR_BUSY;
        end else if (kind != 8'd0) begin
            reject = 1'b1;
            code   = ERR_NOTSUP;
        end else if (!halted) begin
            reject = 1'b1;
            code   = ERR_HALTRES;
        end else if (transfer && (!range_ok || !size_ok)) begin
            reject = 1'b1;
            code   = ERR_NOTSUP;
        end else begin
            accept = 1'b1;
        end
    end

endmodule

// File: rtl/abs_insn_encode.sv
// Module: instruction word builder. Combinational; assumes the command has
// already passed the checker and that DATA_OFFSET fits a signed 12-bit field.
module abs_insn_encode
    import abs_cmd_pkg::*;
#(
    parameter logic [11:0] DATA_OFFSET = 12'h380
) (
    input  logic                  transfer,
    input  logic                  write,
    input  logic                  postexec,
    input  logic                  dbl,
    input  logic [REG_IDX_W-1:0]  gpr_idx,
    output logic [31:0]           word0,
    output logic [31:0]           word1
);

    logic [2:0] f3;

    // First word: load, store or no-op
    always_comb begin
        f3 = dbl ? F3_DBL : F3_WORD;
        if (!transfer)
            word0 = INSN_NOP;
        else if (write)
            word0 = mk_load(f3, gpr_idx, DATA_OFFSET);
        else
            word0 = mk_store(f3, gpr_idx, DATA_OFFSET);
    end

    // Second word: fall through or return to the debug loop
    always_comb word1 = postexec ? INSN_NOP : INSN_EBREAK;

endmodule

// File: rtl/abs_cmd_gen.sv
// Module: top of the abstract register-access command generator. Splits the
// command, runs the checker and encoder, and registers the words and strobes.
// Assumes the controller applies the strobes to its own busy/error/go state.
module abs_cmd_gen
    import abs_cmd_pkg::*;
#(
    parameter logic [11:0] DATA_OFFSET = 12'h380,
    parameter logic [15:0] GPR_BASE    = 16'h1000,
    parameter int          GPR_COUNT   = 32,
    parameter bit          ALLOW_DBL   = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] command,
    input  logic        hart_halted,
    input  logic        busy_in,
    input  logic [2:0]  err_in,
    output logic [31:0] word0,
    output logic [31:0] word1,
    output logic        busy_set,
    output logic        go_set,
    output logic        err_we,
    output logic [2:0]  err_code
);

    logic                 chk_accept;
    logic                 chk_reject;
    cmd_err_e             chk_code;
    logic                 chk_dbl;
    logic [REG_IDX_W-1:0] chk_idx;
    logic [31:0]          enc_w0;
    logic [31:0]          enc_w1;
    logic                 cmd_unused;

    // Bits with no meaning for register access
    assign cmd_unused = command[23] ^ command[19];

    abs_cmd_check #(
        .GPR_BASE  (GPR_BASE),
        .GPR_COUNT (GPR_COUNT),
        .ALLOW_DBL (ALLOW_DBL)
    ) u_check (
        .kind     (command[31:24]),
        .size     (command[22:20]),
        .transfer (command[17]),
        .regno    (command[15:0]),
        .halted   (hart_halted),
        .busy     (busy_in),
        .err      (err_in),
        .accept   (chk_accept),
        .reject   (chk_reject),
        .code     (chk_code),
        .dbl      (chk_dbl),
        .gpr_idx  (chk_idx)
    );

    abs_insn_encode #(
        .DATA_OFFSET (DATA_OFFSET)
    ) u_encode (
        .transfer (command[17]),
        .write    (command[16]),
        .postexec (command[18]),
        .dbl      (chk_dbl),
        .gpr_idx  (chk_idx),
        .word0    (enc_w0),
        .word1    (enc_w1)
    );

    // Strobes and error code, one cycle after start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_set <= 1'b0;
            go_set   <= 1'b0;
            err_we   <= 1'b0;
            err_code <= 3'd0;
        end else begin
            busy_set <= start && chk_accept;
            go_set   <= start && chk_accept;
            err_we   <= start && chk_reject;
            err_code <= (start && chk_reject) ? chk_code : 3'd0;
        end
    end

    // Instruction words, updated only on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word0 <= INSN_NOP;
            word1 <= INSN_EBREAK;
        end else if (start && chk_accept) begin
            word0 <= enc_w0;
            word1 <= enc_w1;
        end
    end

    // R2
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && err_in != 3'd0) |=> (!busy_set && !go_set && !err_we));

    // R3
    busy_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && err_in == 3'd0 && busy_in) |=> (err_we && err_code == 3'd1));

    // R5
    halt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && err_in == 3'd0 && !busy_in && command[31:24] == 8'd0 && !hart_halted)
        |=> (err_we && err_code == 3'd4 && !go_set));

    // R10
    nop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !command[17] && err_in == 3'd0 && !busy_in
         && command[31:24] == 8'd0 && hart_halted) |=> (word0 == INSN_NOP));

    // R11
    second_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_set |-> (word1 == ($past(command[18]) ? INSN_NOP : INSN_EBREAK)));

    // R12
    exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_we && (go_set || busy_set)));

    // R12
    words_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !go_set |-> ($stable(word0) && $stable(word1)));

    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (!busy_set && !go_set && !err_we && err_code == 3'd0));

endmodule

// File: tb/abs_cmd_gen_tb.sv
`timescale 1ns/1ps
module abs_cmd_gen_tb;

    localparam real CYC = 4.0;
    localparam logic [11:0] OFS = 12'h380;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] command = '0;
    logic        hart_halted = 1'b0;
    logic        busy_in = 1'b0;
    logic [2:0]  err_in = '0;
    logic [31:0] word0, word1;
    logic        busy_set, go_set, err_we;
    logic [2:0]  err_code;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [31:0] exp_w0 = 32'h13;
    logic [31:0] exp_w1 = 32'h0010_0073;

    abs_cmd_gen u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .command(command),
        .hart_halted(hart_halted), .busy_in(busy_in), .err_in(err_in),
        .word0(word0), .word1(word1), .busy_set(busy_set), .go_set(go_set),
        .err_we(err_we), .err_code(err_code)
    );

    always #(CYC/2) clk = ~clk;

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: actual cycles=%0d expected below %0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        total = total + 1;
        if (act !== expv) begin
            bad = bad + 1;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, expv);
        end
    endtask

    // Expected outcome: -1 ignored, 0 accepted, >0 error code
    function automatic int outcome(input logic [31:0] c, input logic h,
                                   input logic b, input logic [2:0] e, output string tag);
        int rn;
        int sz;
        rn = int'(c[15:0]);
        sz = int'(c[22:20]);
        if (e != 0) begin tag = "R2"; return -1; end
        if (b) begin tag = "R3"; return 1; end
        if (c[31:24] != 0) begin tag = "R4"; return 2; end
        if (!h) begin tag = "R5"; return 4; end
        if (c[17] && (rn < 4096 || rn > 4127)) begin tag = "R6"; return 2; end
        if (c[17] && !(sz == 2 || sz == 3)) begin tag = "R7"; return 2; end
        if (!c[17]) tag = "R10";
        else if (c[16]) tag = "R8";
        else tag = "R9";
        return 0;
    endfunction

    function automatic logic [31:0] model_w0(input logic [31:0] c);
        int rd, f3, imm;
        if (!c[17]) return 32'h13;
        rd  = int'(c[15:0]) - 4096;
        f3  = (c[22:20] == 3) ? 3 : 2;
        imm = int'(OFS);
        if (c[16])
            return 32'((imm << 20) + (f3 << 12) + (rd << 7) + 3);
        return 32'(((imm / 32) << 25) + (rd << 20) + (f3 << 12) + ((imm % 32) << 7) + 35);
    endfunction

    task automatic run(input logic [31:0] c, input logic h, input logic b, input logic [2:0] e);
        string tag;
        int o;
        o = outcome(c, h, b, e, tag);
        @(negedge clk);
        command = c; hart_halted = h; busy_in = b; err_in = e; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (o == 0) begin
            exp_w0 = model_w0(c);
            exp_w1 = c[18] ? 32'h13 : 32'h0010_0073;
            chk({tag, " go_set"}, {31'd0, go_set}, 32'd1);
            chk("R12 busy_set", {31'd0, busy_set}, 32'd1);
            chk("R12 err_we", {31'd0, err_we}, 32'd0);
            chk({tag, " word0"}, word0, exp_w0);
            chk("R11 word1", word1, exp_w1);
        end else begin
            chk({tag, " go_set"}, {31'd0, go_set}, 32'd0);
            chk({tag, " busy_set"}, {31'd0, busy_set}, 32'd0);
            chk({tag, " err_we"}, {31'd0, err_we}, (o > 0) ? 32'd1 : 32'd0);
            chk({tag, " err_code"}, {29'd0, err_code}, (o > 0) ? 32'(o) : 32'd0);
            chk("R12 word0 hold", word0, exp_w0);
            chk("R12 word1 hold", word1, exp_w1);
        end
        @(negedge clk);
        chk("R13 pulse width", {28'd0, busy_set, go_set, err_we, 1'b0}, 32'd0);
        chk("R13 code idle", {29'd0, err_code}, 32'd0);
    endtask

    function automatic logic [31:0] mk(input logic [7:0] k, input logic [2:0] sz,
                                       input logic [2:0] fl, input logic [15:0] rn);
        return {k, 1'b0, sz, 1'b0, fl, rn};
    endfunction

    initial begin
        logic [15:0] rns [7];
        rns = '{16'h0000, 16'h0FFF, 16'h1000, 16'h1005, 16'h101F, 16'h1020, 16'hFFFF};
        repeat (3) @(negedge clk);
        // R1: reset values while held and right after release
        chk("R1 word0", word0, 32'h13);
        chk("R1 word1", word1, 32'h0010_0073);
        chk("R1 strobes", {29'd0, busy_set, go_set, err_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 err_code", {29'd0, err_code}, 32'd0);
        chk("R1 strobes after release", {29'd0, busy_set, go_set, err_we}, 32'd0);

        // Main sweep: size x flags x regno x halted
        for (int sz = 0; sz < 8; sz++)
            for (int fl = 0; fl < 8; fl++)
                for (int ri = 0; ri < 7; ri++)
                    for (int h = 0; h < 2; h++)
                        run(mk(8'd0, 3'(sz), 3'(fl), rns[ri]), h[0], 1'b0, 3'd0);

        // Unused bits 23 and 19 set on an accepted command
        run(32'h0088_1003 | 32'h0020_0000 | 32'h0001_0000, 1'b1, 1'b0, 3'd0);

        // R4: nonzero command type, with halted either way
        for (int k = 1; k < 256; k = k * 2 + 1)
            for (int h = 0; h < 2; h++)
                run(mk(8'(k), 3'd2, 3'b011, 16'h1001), h[0], 1'b0, 3'd0);

        // R3: busy held, various commands
        for (int fl = 0; fl < 8; fl++)
            run(mk(8'd0, 3'd3, 3'(fl), 16'h1004), 1'b1, 1'b1, 3'd0);
        run(mk(8'h02, 3'd2, 3'b010, 16'h1004), 1'b0, 1'b1, 3'd0);

        // R2: every nonzero error value, with and without busy
        for (int e = 1; e < 8; e++)
            for (int b = 0; b < 2; b++)
                run(mk(8'd0, 3'd2, 3'b111, 16'h1011), 1'b1, b[0], 3'(e));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule